// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This controller moves a processor subsystem between a running state and two low-power states, a light sleep and a deep sleep, and drives the clock-gating and PLL controls that go with each state. There are three ways in: a wait-for-interrupt pulse, a wait-for-event pulse, and an exception return while the sleep-on-exit control bit is set. One deep-select control bit picks the target state for all three. A wake-up condition that is already present when the request arrives cancels the request, so the core keeps running.

In light sleep only the CPU clock stops. In deep sleep the PLL also turns off, and the system moves to a slow clock. A divider field, captured when deep sleep is entered, sets the speed of that slow clock. When the controller leaves deep sleep, it holds the CPU clock gated for a fixed relock period and then returns to the PLL clock. After a wake from deep sleep a lockout window opens, and a deep request made inside that window enters light sleep instead. The oscillator stays on in every state. Debug accesses are blocked whenever the core is not running.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller returns to run: `mode`=00, `cpu_clk_en`=1, `periph_clk_en`=1, `pll_en`=1, `osc_en`=1, `clk_sel`=0, `dbg_block`=0, `slow_div`=0.
- R2: An accepted entry request changes `mode` on the next clock edge. It goes to 01 (sleep) when `deep_sel`=0. It goes to 10 (deep sleep) when `deep_sel`=1 and no lockout is running. From sleep the only next state is sleep or run.
- R3: A request is dropped, and `mode` stays 00, when its wake-up condition is true in the same cycle. For a wait-for-event request the condition is `event_in`=1. For every other request it is any bit of `irq_pending` set.
- R4: A state entered by wait-for-interrupt or by sleep-on-exit ends only when a bit of `irq_pending` is set, and `event_in` alone does not end it. A state entered by a request in which `wfi_req` is high is of this kind, even when `wfe_req` is high too.
- R5: A state entered by a request in which `wfe_req` is the only request ends when `event_in`=1. A set bit of `irq_pending` alone does not end it.
- R6: `exc_return` is an entry request only when `sleep_on_exit`=1. With `sleep_on_exit`=0 it has no effect, and `sleep_on_exit` alone has no effect.
- R7: In sleep, `cpu_clk_en`=0 while `periph_clk_en`=1, `pll_en`=1 and `clk_sel`=0. Waking from sleep returns `mode` to 00 with `cpu_clk_en`=1 on the edge that samples the wake-up condition.
- R8: In deep sleep, `cpu_clk_en`=0, `pll_en`=0 and `clk_sel`=1 (slow clock). `slow_div` shows the `dslp_div` value sampled on the entry edge, and later changes to `dslp_div` do not alter it. Whenever `clk_sel`=0, `slow_div` is 0.
- R9: `osc_en` is 1 in every state, and `osc_off_req` has no effect on it or on `mode`.
- R10: `dbg_block` is 1 exactly when `mode` is not 00.
- R11: A wake from deep sleep puts `mode` at 11 for RELOCK_CYCLES cycles, with `cpu_clk_en`=0, `pll_en`=1 and `clk_sel`=1. After that `mode` returns to 00 with `clk_sel`=0 and `cpu_clk_en`=1.
- R12: A deep request sampled within LOCKOUT_CYCLES edges after the edge that left deep sleep enters sleep (01) instead. A deep request sampled after that window enters deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt pulse |
| wfe_req | input | 1 | Wait-for-event pulse |
| exc_return | input | 1 | Return-from-last-exception pulse |
| sleep_on_exit | input | 1 | Control bit: enter low power on exception return |
| deep_sel | input | 1 | Control bit: 0 sleep, 1 deep sleep |
| irq_pending | input | NUM_IRQ | Pending interrupt lines |
| event_in | input | 1 | Event input |
| dslp_div | input | DIV_W | Slow-clock divider used in deep sleep |
| osc_off_req | input | 1 | Oscillator shut-off request (ignored) |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| clk_sel | output | 1 | Clock source: 0 PLL, 1 slow clock |
| slow_div | output | DIV_W | Divider in use while on the slow clock |
| dbg_block | output | 1 | Debug access block |
| mode | output | 2 | 00 run, 01 sleep, 10 deep sleep, 11 waking |

## Verification
An entry request and its own wake-up condition can arrive in the same cycle. The bench provokes this by raising a pending interrupt or `event_in` in the same cycle as the request pulse, and it also raises the condition that belongs to the other kind of request. After that edge it checks that `mode` stays 00 only when the matching condition was present. A second collision is tested as well: a deep request that lands inside the lockout window that follows a deep wake. The bench judges it by whether `mode` reads 01 or 10.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      MODE_RUN   = 2'b00,
      MODE_SLEEP = 2'b01,
      MODE_DEEP  = 2'b10,
      MODE_WAKE  = 2'b11
   } lpm_mode_e;

   typedef enum logic {
      SRC_IRQ = 1'b0,
      SRC_EVT = 1'b1
   } wake_src_e;
endpackage

// File: rtl/lpm_downcounter.sv
module lpm_downcounter #(
   parameter int unsigned SPAN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy,
   output logic final_tick
);
   generate
      if (SPAN == 0) begin : g_none
         logic unused_in;
         assign unused_in  = ^{clk, rst_n, load};
         assign busy       = 1'b0;
         assign final_tick = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(SPAN + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (load)        cnt <= CW'(SPAN);
            else if (cnt != '0)   cnt <= cnt - CW'(1);
         end

         assign busy       = (cnt != '0);
         assign final_tick = (cnt == CW'(1));

         AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == '0 && !load) |=> (cnt == '0)); // R12
         AST_CNT_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (cnt == CW'(SPAN))); // R11
      end
   endgenerate
endmodule

// File: rtl/lpm_entry_decode.sv
module lpm_entry_decode
   import lpm_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 8
) (
   input  logic               wfi_req,
   input  logic               wfe_req,
   input  logic               exc_return,
   input  logic               sleep_on_exit,
   input  logic [NUM_IRQ-1:0] irq_pending,
   input  logic               event_in,
   input  logic               deep_sel,
   input  logic               lockout_busy,
   output logic               irq_any,
   output logic               enter,
   output wake_src_e          src,
   output logic               go_deep
);
   logic soe_req;
   logic any_req;
   logic blocked;

   assign irq_any = |irq_pending;
   assign soe_req = exc_return & sleep_on_exit;
   assign any_req = wfi_req | wfe_req | soe_req;

   always_comb begin
      if (wfe_req && !wfi_req && !soe_req) src = SRC_EVT;
      else                                 src = SRC_IRQ;
   end

   assign blocked = (src == SRC_EVT) ? event_in : irq_any;
   assign enter   = any_req & ~blocked;
   assign go_deep = deep_sel & ~lockout_busy;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned NUM_IRQ        = 8,
   parameter int unsigned DIV_W          = 3,
   parameter int unsigned LOCKOUT_CYCLES = 1000,
   parameter int unsigned RELOCK_CYCLES  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wfi_req,
   input  logic               wfe_req,
   input  logic               exc_return,
   input  logic               sleep_on_exit,
   input  logic               deep_sel,
   input  logic [NUM_IRQ-1:0] irq_pending,
   input  logic               event_in,
   input  logic [DIV_W-1:0]   dslp_div,
   input  logic               osc_off_req,
   output logic               cpu_clk_en,
   output logic               periph_clk_en,
   output logic               pll_en,
   output logic               osc_en,
   output logic               clk_sel,
   output logic [DIV_W-1:0]   slow_div,
   output logic               dbg_block,
   output logic [1:0]         mode
);
   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("lpm_ctrl: NUM_IRQ must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("lpm_ctrl: DIV_W must be at least 1");
      end
      if (RELOCK_CYCLES < 1) begin : g_bad_relock
         $error("lpm_ctrl: RELOCK_CYCLES must be at least 1");
      end
   endgenerate

   lpm_mode_e        state;
   wake_src_e        src_q;
   logic [DIV_W-1:0] div_q;

   logic      irq_any;
   logic      enter;
   wake_src_e src_new;
   logic      go_deep;
   logic      lock_busy;
   logic      lock_last;
   logic      relock_busy;
   logic      relock_last;
   logic      wake_hit;
   logic      deep_wake;
   logic      unused_sig;

   assign unused_sig = ^{osc_off_req, lock_last, relock_busy};

   lpm_entry_decode #(.NUM_IRQ(NUM_IRQ)) u_decode (
      .wfi_req      (wfi_req),
      .wfe_req      (wfe_req),
      .exc_return   (exc_return),
      .sleep_on_exit(sleep_on_exit),
      .irq_pending  (irq_pending),
      .event_in     (event_in),
      .deep_sel     (deep_sel),
      .lockout_busy (lock_busy),
      .irq_any      (irq_any),
      .enter        (enter),
      .src          (src_new),
      .go_deep      (go_deep)
   );

   assign wake_hit  = (src_q == SRC_EVT) ? event_in : irq_any;
   assign deep_wake = (state == MODE_DEEP) && wake_hit;

   lpm_downcounter #(.SPAN(LOCKOUT_CYCLES)) u_lockout (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (deep_wake),
      .busy      (lock_busy),
      .final_tick(lock_last)
   );

   lpm_downcounter #(.SPAN(RELOCK_CYCLES)) u_relock (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (deep_wake),
      .busy      (relock_busy),
      .final_tick(relock_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= MODE_RUN;
         src_q <= SRC_IRQ;
         div_q <= '0;
      end else begin
         unique case (state)
            MODE_RUN: begin
               if (enter) begin
                  src_q <= src_new;
                  if (go_deep) begin
                     state <= MODE_DEEP;
                     div_q <= dslp_div;
                  end else begin
                     state <= MODE_SLEEP;
                  end
               end
            end
            MODE_SLEEP: if (wake_hit)    state <= MODE_RUN;
            MODE_DEEP:  if (wake_hit)    state <= MODE_WAKE;
            MODE_WAKE:  if (relock_last) state <= MODE_RUN;
            default:                     state <= MODE_RUN;
         endcase
      end
   end

   always_comb begin
      cpu_clk_en    = 1'b0;
      periph_clk_en = 1'b1;
      pll_en        = 1'b1;
      clk_sel       = 1'b0;
      dbg_block     = 1'b1;
      unique case (state)
         MODE_RUN: begin
            cpu_clk_en = 1'b1;
            dbg_block  = 1'b0;
         end
         MODE_SLEEP: ;
         MODE_DEEP: begin
            pll_en  = 1'b0;
            clk_sel = 1'b1;
         end
         MODE_WAKE: clk_sel = 1'b1;
         default: ;
      endcase
   end

   assign osc_en   = 1'b1;
   assign slow_div = clk_sel ? div_q : '0;
   assign mode     = state;

   AST_WFI_PENDING_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_RUN && wfi_req && irq_any) |=> (state == MODE_RUN)); // R3
   AST_IRQ_WAKES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_SLEEP && src_q == SRC_IRQ && irq_any) |=> (state == MODE_RUN)); // R4
   AST_EVT_WAKES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_SLEEP && src_q == SRC_EVT && event_in) |=> (state == MODE_RUN)); // R5
   AST_SLEEP_NO_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_SLEEP) |=> (state == MODE_SLEEP || state == MODE_RUN)); // R2
   AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_DEEP && $past(state) == MODE_DEEP) |-> $stable(slow_div)); // R8
   AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_WAKE && relock_last) |=> (state == MODE_RUN && cpu_clk_en)); // R11
   AST_LOCKOUT_SHALLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_RUN && lock_busy) |=> (state != MODE_DEEP)); // R12
endmodule

// File: tb/lpm_ctrl_test.sv
`timescale 1ns/100ps
module lpm_ctrl_test;
   localparam int unsigned NI = 8;
   localparam int unsigned DW = 3;
   localparam int unsigned LOCK = 40;
   localparam int unsigned RELOCK = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wfi_req = 0, wfe_req = 0, exc_return = 0, sleep_on_exit = 0, deep_sel = 0;
   logic [NI-1:0] irq_pending = '0;
   logic event_in = 0, osc_off_req = 0;
   logic [DW-1:0] dslp_div = '0;
   logic cpu_clk_en, periph_clk_en, pll_en, osc_en, clk_sel, dbg_block;
   logic [DW-1:0] slow_div;
   logic [1:0] mode;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lpm_ctrl #(.NUM_IRQ(NI), .DIV_W(DW), .LOCKOUT_CYCLES(LOCK), .RELOCK_CYCLES(RELOCK)) uut (
      .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
      .exc_return(exc_return), .sleep_on_exit(sleep_on_exit), .deep_sel(deep_sel),
      .irq_pending(irq_pending), .event_in(event_in), .dslp_div(dslp_div),
      .osc_off_req(osc_off_req), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .pll_en(pll_en), .osc_en(osc_en), .clk_sel(clk_sel), .slow_div(slow_div),
      .dbg_block(dbg_block), .mode(mode)
   );

   // fields: wfi wfe exc soe | irq[7:0] | evt | expect_enter
   localparam logic [13:0] VEC [11] = '{
      14'b1000_00000000_0_1,  // R4 plain WFI
      14'b1000_00000100_0_0,  // R3 WFI with irq pending
      14'b1000_00000000_1_1,  // R3 event does not block WFI
      14'b0100_00000000_0_1,  // R5 plain WFE
      14'b0100_00000000_1_0,  // R3 WFE with event
      14'b0100_10000000_0_1,  // R5 irq does not block WFE
      14'b0011_00000000_0_1,  // R6 sleep-on-exit
      14'b0010_00000000_0_0,  // R6 exc return, bit clear
      14'b0011_00000001_0_0,  // R3 sleep-on-exit with irq
      14'b1100_00000000_1_1,  // R4 WFI wins over WFE
      14'b0001_00000000_0_0   // R6 bit alone
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_dbg();
      chk("R10", {31'd0, dbg_block}, {31'd0, (mode != 2'b00)});
      chk("R9", {31'd0, osc_en}, 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 mode", {30'd0, mode}, 32'd0);
      chk("R1 clocks", {26'd0, cpu_clk_en, periph_clk_en, pll_en, osc_en, clk_sel, dbg_block},
          32'b111100);
      chk("R1 div", {29'd0, slow_div}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, shallow sleep only
      foreach (VEC[i]) begin
         logic [13:0] v;
         logic evt_kind;
         v = VEC[i];
         evt_kind = v[12] & ~v[13] & ~(v[11] & v[10]);
         wfi_req = v[13]; wfe_req = v[12]; exc_return = v[11]; sleep_on_exit = v[10];
         irq_pending = v[9:2]; event_in = v[1];
         @(negedge clk);
         wfi_req = 0; wfe_req = 0; exc_return = 0; sleep_on_exit = 0;
         irq_pending = '0; event_in = 0;
         chk(v[0] ? "R2 enter" : "R3/R6 drop", {30'd0, mode}, v[0] ? 32'd1 : 32'd0);
         check_dbg();
         if (v[0]) begin
            chk("R7", {28'd0, cpu_clk_en, periph_clk_en, pll_en, clk_sel}, 32'b0110);
            if (evt_kind) irq_pending = 8'h10; else event_in = 1'b1;
            @(negedge clk);
            chk(evt_kind ? "R5 irq ignored" : "R4 event ignored", {30'd0, mode}, 32'd1);
            irq_pending = '0; event_in = 0;
            if (evt_kind) event_in = 1'b1; else irq_pending = 8'h20;
            @(negedge clk);
            chk(evt_kind ? "R5 wake" : "R4 wake", {30'd0, mode}, 32'd0);
            chk("R7 cpu back", {31'd0, cpu_clk_en}, 32'd1);
            irq_pending = '0; event_in = 0;
         end
         @(negedge clk);
      end

      // deep sleep entry and divider capture
      deep_sel = 1; dslp_div = 3'd5; wfi_req = 1;
      @(negedge clk);
      wfi_req = 0;
      chk("R2 deep", {30'd0, mode}, 32'd2);
      chk("R8 clocks", {29'd0, cpu_clk_en, pll_en, clk_sel}, 32'b001);
      chk("R8 div", {29'd0, slow_div}, 32'd5);
      check_dbg();
      dslp_div = 3'd2; osc_off_req = 1;
      @(negedge clk);
      chk("R8 div held", {29'd0, slow_div}, 32'd5);
      chk("R9 osc", {31'd0, osc_en}, 32'd1);
      chk("R9 mode", {30'd0, mode}, 32'd2);
      osc_off_req = 0; event_in = 1;
      @(negedge clk);
      chk("R4 deep event ignored", {30'd0, mode}, 32'd2);
      event_in = 0; irq_pending = 8'h02;
      @(negedge clk);
      irq_pending = '0;
      chk("R11 wake", {30'd0, mode}, 32'd3);
      chk("R11 clocks", {29'd0, cpu_clk_en, pll_en, clk_sel}, 32'b011);
      check_dbg();
      repeat (RELOCK - 1) @(negedge clk);
      chk("R11 still waking", {30'd0, mode}, 32'd3);
      @(negedge clk);
      chk("R11 run", {30'd0, mode}, 32'd0);
      chk("R11 pll clock", {30'd0, cpu_clk_en, clk_sel}, 32'b10);
      chk("R8 div cleared", {29'd0, slow_div}, 32'd0);

      // lockout: deep request falls back to sleep
      wfi_req = 1;
      @(negedge clk);
      wfi_req = 0;
      chk("R12 lockout sleep", {30'd0, mode}, 32'd1);
      irq_pending = 8'h01;
      @(negedge clk);
      irq_pending = '0;
      chk("R12 wake", {30'd0, mode}, 32'd0);
      repeat (LOCK) @(negedge clk);
      wfi_req = 1;
      @(negedge clk);
      wfi_req = 0;
      chk("R12 deep after lockout", {30'd0, mode}, 32'd2);

      // reset from deep sleep
      rst_n = 0;
      @(negedge clk);
      chk("R1 reset from deep", {30'd0, mode}, 32'd0);
      chk("R1 clocks after", {26'd0, cpu_clk_en, periph_clk_en, pll_en, osc_en, clk_sel, dbg_block},
          32'b111100);
      rst_n = 1;
      @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule